// File: doc/BRIEF.md
# Texture Coordinate Wrap Unit

This block takes an integer texel coordinate for each of the two texture axes (s and t) and folds it into the legal index range of that axis. The folding follows a 3-bit mode selected separately per axis. The coordinate is a signed two's-complement value. The extent of each axis is an 11-bit size. Sizes are assumed to be powers of two, so the remainder is taken by masking and no divider is needed.

Each axis gives back an in-range index and a flag. The flag tells the texel fetch stage to use the border colour instead of memory. Both axes are registered together, so results appear one clock after the request, with a valid strobe that tracks the request strobe.

Beyond the four usual modes, the unit defines behaviour for mode codes 4 to 7. In modes 4 and 5 the handling depends on the sign of the coordinate. Modes 6 and 7 act as plain repeat.

Top module: `tex_wrap_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge, and it is 0 while `rst_n` is low.
- R2: Mode code 0 (clamp to edge) yields 0 for a negative coordinate, size-1 for a coordinate at or above size, and the coordinate itself otherwise; the border flag stays 0.
- R3: Mode code 1 (clamp to border) raises the border flag exactly when the coordinate is negative or at or above size; the index output carries the clamp-to-edge value.
- R4: Mode code 2 (repeat) yields the coordinate modulo size as a non-negative value, also for negative coordinates.
- R5: Mode code 3 (mirrored repeat) yields the repeat value r when floor(coordinate/size) is even and size-1-r when it is odd.
- R6: Mode code 4 acts as repeat for a negative coordinate and as clamp to edge for a non-negative one.
- R7: Mode code 5 acts as repeat for a negative coordinate, with the border flag 0, and as clamp to border for a non-negative one.
- R8: Mode codes 6 and 7 act as repeat.
- R9: The border flag is 0 for every mode code other than 1 and 5.
- R10: The s axis uses `s_coord`, `s_mode` and `width`; the t axis uses `t_coord`, `t_mode` and `height`; neither axis affects the other.
- R11: The coordinate is a COORD_W-bit two's-complement value, with full range handled. The size is any power of two from 1 to 1024 held in SIZE_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| s_coord | input | COORD_W | Signed s coordinate |
| t_coord | input | COORD_W | Signed t coordinate |
| width | input | SIZE_W | Extent of the s axis |
| height | input | SIZE_W | Extent of the t axis |
| s_mode | input | 3 | Wrap mode code for s |
| t_mode | input | 3 | Wrap mode code for t |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| s_out | output | SIZE_W | Wrapped s index |
| t_out | output | SIZE_W | Wrapped t index |
| s_border | output | 1 | Use border colour for s |
| t_border | output | 1 | Use border colour for t |

## Verification
The bench builds the unit with COORD_W=16 and SIZE_W=11.

With 16-bit coordinates, the bench can drive the most negative and most positive values. At the largest size of 1024, these values lie dozens of periods away from the origin. This checks that the mirror parity is taken from the correct coordinate bit, even far from zero.

With the 11-bit size, the bench sweeps sizes from 1 up to 1024. The sweep covers the single-texel case, where every mode must return index 0, and the widest mask the field allows.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // Mode codes of the per-axis wrap field
   typedef enum logic [2:0] {
      WM_EDGE        = 3'd0,
      WM_BORDER      = 3'd1,
      WM_REPEAT      = 3'd2,
      WM_MIRROR      = 3'd3,
      WM_EDGE_NEGREP = 3'd4,
      WM_BORD_NEGREP = 3'd5,
      WM_REPEAT_6    = 3'd6,
      WM_REPEAT_7    = 3'd7
   } wrap_mode_e;

   // Operation actually applied once the sign has been considered
   typedef enum logic [1:0] {
      OP_CLAMP  = 2'd0,
      OP_BORDER = 2'd1,
      OP_REPEAT = 2'd2,
      OP_MIRROR = 2'd3
   } wrap_op_e;

   localparam int unsigned AXES = 2;

endpackage

// File: rtl/tw_mode_decode.sv
module tw_mode_decode
   import tw_pkg::*;
(
   input  logic [2:0] mode,
   input  logic       negative,
   output wrap_op_e   op
);

   always_comb begin
      unique case (wrap_mode_e'(mode))
         WM_EDGE:        op = OP_CLAMP;
         WM_BORDER:      op = OP_BORDER;
         WM_REPEAT:      op = OP_REPEAT;
         WM_MIRROR:      op = OP_MIRROR;
         WM_EDGE_NEGREP: op = negative ? OP_REPEAT : OP_CLAMP;
         WM_BORD_NEGREP: op = negative ? OP_REPEAT : OP_BORDER;
         default:        op = OP_REPEAT;
      endcase
   end

endmodule

// File: rtl/tw_range_cmp.sv
module tw_range_cmp #(
   parameter int unsigned COORD_W = 16,
   parameter int unsigned SIZE_W  = 11
) (
   input  logic signed [COORD_W-1:0] coord,
   input  logic        [SIZE_W-1:0]  size,
   output logic                      below,
   output logic                      at_or_above
);

   localparam int unsigned EXT_W = ((COORD_W > SIZE_W) ? COORD_W : SIZE_W) + 1;

   logic signed [EXT_W-1:0] coord_ext;
   logic signed [EXT_W-1:0] size_ext;

   assign coord_ext   = EXT_W'(coord);
   assign size_ext    = $signed({{(EXT_W-SIZE_W){1'b0}}, size});
   assign below       = coord[COORD_W-1];
   assign at_or_above = (coord_ext >= size_ext);

endmodule

// File: rtl/tw_axis.sv
module tw_axis
   import tw_pkg::*;
#(
   parameter int unsigned COORD_W = 16,
   parameter int unsigned SIZE_W  = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req,
   input  logic signed [COORD_W-1:0] coord,
   input  logic        [SIZE_W-1:0]  size,
   input  logic        [2:0]         mode,
   output logic        [SIZE_W-1:0]  idx_q,
   output logic                      border_q
);

   logic              below;
   logic              above;
   wrap_op_e          op;
   logic [SIZE_W-1:0] mask;
   logic [SIZE_W-1:0] low_bits;
   logic [SIZE_W-1:0] rep_val;
   logic [SIZE_W-1:0] mir_val;
   logic [SIZE_W-1:0] edge_val;
   logic              odd_period;
   logic [SIZE_W-1:0] idx_d;
   logic              border_d;

   tw_range_cmp #(.COORD_W(COORD_W), .SIZE_W(SIZE_W)) i_cmp (
      .coord       (coord),
      .size        (size),
      .below       (below),
      .at_or_above (above)
   );

   tw_mode_decode i_dec (
      .mode     (mode),
      .negative (below),
      .op       (op)
   );

   // Power-of-two size: remainder by mask, period parity from the size bit
   assign mask       = size - 1'b1;
   assign low_bits   = coord[SIZE_W-1:0];
   assign rep_val    = low_bits & mask;
   assign odd_period = |(low_bits & size);
   assign mir_val    = odd_period ? (mask - rep_val) : rep_val;
   assign edge_val   = below ? '0 : (above ? mask : low_bits);

   always_comb begin
      border_d = 1'b0;
      unique case (op)
         OP_CLAMP:  idx_d = edge_val;
         OP_BORDER: begin
            idx_d    = edge_val;
            border_d = below | above;
         end
         OP_REPEAT: idx_d = rep_val;
         default:   idx_d = mir_val;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         border_q <= 1'b0;
      end else if (req) begin
         idx_q    <= idx_d;
         border_q <= border_d;
      end
   end

endmodule

// File: rtl/tex_wrap_unit.sv
module tex_wrap_unit
   import tw_pkg::*;
#(
   parameter int unsigned COORD_W = 16,
   parameter int unsigned SIZE_W  = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic signed [COORD_W-1:0] s_coord,
   input  logic signed [COORD_W-1:0] t_coord,
   input  logic        [SIZE_W-1:0]  width,
   input  logic        [SIZE_W-1:0]  height,
   input  logic        [2:0]         s_mode,
   input  logic        [2:0]         t_mode,
   output logic                      out_valid,
   output logic        [SIZE_W-1:0]  s_out,
   output logic        [SIZE_W-1:0]  t_out,
   output logic                      s_border,
   output logic                      t_border
);

   generate
      if (COORD_W <= SIZE_W) begin : g_bad_coord_w
         $error("COORD_W must exceed SIZE_W");
      end
      if (SIZE_W < 2) begin : g_bad_size_w
         $error("SIZE_W must be at least 2");
      end
   endgenerate

   logic signed [COORD_W-1:0] ax_coord  [AXES];
   logic        [SIZE_W-1:0]  ax_size   [AXES];
   logic        [2:0]         ax_mode   [AXES];
   logic        [SIZE_W-1:0]  ax_idx    [AXES];
   logic                      ax_border [AXES];

   assign ax_coord[0] = s_coord;
   assign ax_size[0]  = width;
   assign ax_mode[0]  = s_mode;
   assign ax_coord[1] = t_coord;
   assign ax_size[1]  = height;
   assign ax_mode[1]  = t_mode;

   generate
      for (genvar a = 0; a < AXES; a++) begin : g_axis
         tw_axis #(.COORD_W(COORD_W), .SIZE_W(SIZE_W)) i_axis (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (in_valid),
            .coord    (ax_coord[a]),
            .size     (ax_size[a]),
            .mode     (ax_mode[a]),
            .idx_q    (ax_idx[a]),
            .border_q (ax_border[a])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   assign s_out    = ax_idx[0];
   assign t_out    = ax_idx[1];
   assign s_border = ax_border[0];
   assign t_border = ax_border[1];

endmodule

// File: rtl/tw_chk.sv
module tw_chk #(
   parameter int unsigned COORD_W = 16,
   parameter int unsigned SIZE_W  = 11
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic signed [COORD_W-1:0] s_coord,
   input logic        [SIZE_W-1:0]  width,
   input logic        [SIZE_W-1:0]  height,
   input logic        [2:0]         s_mode,
   input logic        [2:0]         t_mode,
   input logic                      out_valid,
   input logic        [SIZE_W-1:0]  s_out,
   input logic        [SIZE_W-1:0]  t_out,
   input logic                      s_border,
   input logic                      t_border
);

   // R1
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R1
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R11
   s_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (s_out < $past(width)));

   // R11
   t_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (t_out < $past(height)));

   // R9
   s_border_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && s_mode != 3'd1 && s_mode != 3'd5) |=> !s_border);

   // R9
   t_border_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && t_mode != 3'd1 && t_mode != 3'd5) |=> !t_border);

   // R7
   neg_border_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && s_mode == 3'd5 && s_coord[COORD_W-1]) |=> !s_border);

endmodule

bind tex_wrap_unit tw_chk #(.COORD_W(COORD_W), .SIZE_W(SIZE_W)) i_tw_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .s_coord   (s_coord),
   .width     (width),
   .height    (height),
   .s_mode    (s_mode),
   .t_mode    (t_mode),
   .out_valid (out_valid),
   .s_out     (s_out),
   .t_out     (t_out),
   .s_border  (s_border),
   .t_border  (t_border)
);

// File: tb/test_tex_wrap_unit.sv
module test_tex_wrap_unit;

   localparam int COORD_W  = 16;
   localparam int SIZE_W   = 11;
   localparam time CLK_PER = 10ns;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      in_valid = 1'b0;
   logic signed [COORD_W-1:0] s_coord = '0;
   logic signed [COORD_W-1:0] t_coord = '0;
   logic        [SIZE_W-1:0]  width = 11'd1;
   logic        [SIZE_W-1:0]  height = 11'd1;
   logic        [2:0]         s_mode = '0;
   logic        [2:0]         t_mode = '0;
   logic                      out_valid;
   logic        [SIZE_W-1:0]  s_out;
   logic        [SIZE_W-1:0]  t_out;
   logic                      s_border;
   logic                      t_border;

   int checks = 0;
   int errors = 0;
   logic last_iv = 1'b0;
   bit done = 1'b0;

   typedef struct {
      int s_idx; bit s_b; int s_m;
      int t_idx; bit t_b; int t_m;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PER/2) clk = ~clk;

   tex_wrap_unit #(.COORD_W(COORD_W), .SIZE_W(SIZE_W)) i_tex_wrap_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .s_coord(s_coord), .t_coord(t_coord), .width(width), .height(height),
      .s_mode(s_mode), .t_mode(t_mode), .out_valid(out_valid),
      .s_out(s_out), .t_out(t_out), .s_border(s_border), .t_border(t_border)
   );

   function automatic string idx_req(int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic string brd_req(int m);
      if (m == 1) return "R3";
      if (m == 5) return "R7";
      return "R9";
   endfunction

   // Reference model written from the requirement text
   task automatic model(input int c, input int size, input int m,
                        output int o, output bit b);
      int r, p, op;
      bit neg;
      neg = (c < 0);
      case (m)
         0: op = 0;
         1: op = 1;
         3: op = 3;
         4: op = neg ? 2 : 0;
         5: op = neg ? 2 : 1;
         default: op = 2;
      endcase
      r = c % size;
      if (r < 0) r += size;
      p = (c - r) / size;
      b = 1'b0;
      case (op)
         0, 1: begin
            o = (c < 0) ? 0 : ((c >= size) ? size - 1 : c);
            if (op == 1) b = (c < 0) || (c >= size);
         end
         2: o = r;
         default: o = ((p % 2) != 0) ? size - 1 - r : r;
      endcase
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: applies one request and pushes its expected result
   task automatic send(input int sc, input int sw, input int sm,
                       input int tc, input int th, input int tm);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      s_coord  = COORD_W'(sc);
      t_coord  = COORD_W'(tc);
      width    = SIZE_W'(sw);
      height   = SIZE_W'(th);
      s_mode   = 3'(sm);
      t_mode   = 3'(tm);
      model(sc, sw, sm, e.s_idx, e.s_b);
      model(tc, th, tm, e.t_idx, e.t_b);
      e.s_m = sm;
      e.t_m = tm;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         s_coord  = 16'sh7abc;
         s_mode   = 3'd1;
      end
   endtask

   always @(posedge clk) last_iv <= in_valid;

   // Monitor: compares every result against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(out_valid === last_iv, "R1 valid delay", int'(out_valid), int'(last_iv));
         if (out_valid === 1'b1) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R1 result without request", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(int'(s_out) == e.s_idx, {idx_req(e.s_m), " R10 s index"}, int'(s_out), e.s_idx);
               check(s_border == e.s_b, {brd_req(e.s_m), " R10 s border"}, int'(s_border), int'(e.s_b));
               check(int'(t_out) == e.t_idx, {idx_req(e.t_m), " R10 t index"}, int'(t_out), e.t_idx);
               check(t_border == e.t_b, {brd_req(e.t_m), " R10 t border"}, int'(t_border), int'(e.t_b));
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int sizes[5];
      int cl[12];
      sizes = '{1, 4, 16, 256, 1024};
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R1 reset state", int'(out_valid), 0);
      check(s_border === 1'b0 && t_border === 1'b0, "R1 reset border", int'(s_border), 0);
      rst_n = 1'b1;
      idle(2);
      // R11: full signed range and sizes 1..1024
      for (int si = 0; si < 5; si++) begin
         int sz;
         int tz;
         sz = sizes[si];
         tz = sizes[(si + 2) % 5];
         cl = '{-32768, -2049, -9, -1, 0, 1, sz - 1, sz, sz + 1, 2*sz + 3, 3*sz - 1, 32767};
         for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 12; k++) begin
               send(cl[k], sz, m, cl[11 - k], tz, (m + 3) % 8);
            end
            idle(m % 3);
         end
      end
      // R10: same coordinate, different sizes and modes per axis
      send(-5, 4, 3, -5, 8, 2);
      send(700, 1024, 1, 700, 512, 0);
      idle(3);
      done = 1'b1;
      check(sb_q.size() == 0, "R1 pending results", sb_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule